// File: doc/BRIEF.md
# Timer Pin Control with GPIO and Edge Capture

This block controls the single external pin of one general purpose timer channel. Software can use the pin as a plain GPIO, either driving it or reading it. The pin can also act as an edge-sensitive interrupt source. A small register bus holds two words. One is a 32-bit configuration word that selects the channel function, the GPIO drive, open-drain signalling, interrupt enable and the capture edge. The other is a status word that returns the pin level and the latched edge flags.

The pin input is resynchronised before it is used. A selected edge sets a sticky flag, and software clears that flag by writing a one to it. One interrupt line is raised while any flag is set and interrupts are enabled. Whenever edge capture is configured, the pin is forced to be an input. Counting, compare and PWM waveforms belong to other parts of the timer and are not in this block.

Top module: `tpin_ctrl`

## Requirements
- R1: After reset the configuration word reads 0, every status flag reads 0, `pin_oe` is 0 and `irq` is 0.
- R2: A write with `reg_sel`=0 stores all 32 bits of `reg_wdata` in the configuration word, and the same value reads back on `reg_rdata` while `reg_sel`=0.
- R3: When the function field (configuration bits [2:0]) is 4 (GPIO), the edge field is 0 and the drive field (bits [5:4]) is 2'b11, the pin is driven high (`pin_oe`=1, `pin_out`=1). Drive value 2'b10 drives the pin low (`pin_oe`=1, `pin_out`=0). Any drive value with bit 5 clear leaves `pin_oe`=0.
- R4: When configuration bit 9 (open-drain) is 1, a high drive releases the pin (`pin_oe`=0) and a low drive still drives the pin low.
- R5: Whenever the edge field (configuration bits [17:16]) is not 0, `pin_oe` is 0 whatever the drive field holds.
- R6: Status bit 8 (`reg_sel`=1) shows `pin_in` after a two-flop synchronizer. A change of the pin is visible after the second rising clock edge.
- R7: With edge field 2'b01 a rising pin edge sets status flag bit 0, and a falling edge sets no flag.
- R8: With edge field 2'b10 a falling edge sets status flag bit 1. With 2'b11 both edges are captured, rising in bit 0 and falling in bit 1. With 2'b00 no flag is set even when the function field is 1 (capture).
- R9: A write with `reg_sel`=1 clears each flag in bits [3:0] whose `reg_wdata` bit is 1. Flags written with 0 keep their value.
- R10: If an edge sets a flag in the same cycle as a write that clears it, the flag stays set.
- R11: `irq` is 1 exactly while at least one flag is set and configuration bit 8 is 1.
- R12: When the function field is not 4, the drive field has no effect and `pin_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 1 | Register select: 0 for configuration, 1 for status |
| reg_we | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register, combinational |
| pin_in | input | 1 | Level seen on the pad |
| pin_out | output | 1 | Value driven onto the pad |
| pin_oe | output | 1 | Pad output enable |
| irq | output | 1 | Interrupt request |

## Verification
The capture path is tried with single rising edges, single falling edges and full high-low pulses under each of the four edge selections. This separates which edge sets which flag, and it shows that edge value 0 captures nothing. Clear writes are tried on one flag at a time, so that a clear which wipes every flag is caught. One clear write is timed to fall in the exact cycle a new edge lands, to show that the set wins. The drive cases go through high, low and input drive values in GPIO mode, with open-drain on and off, under a non-GPIO function, and with capture enabled. This tells the drive encoding apart from the two overrides.

// File: rtl/tpin_pkg.sv
package tpin_pkg;

    typedef enum logic [2:0] {
        FN_OFF     = 3'd0,
        FN_CAPTURE = 3'd1,
        FN_COMPARE = 3'd2,
        FN_PWM     = 3'd3,
        FN_GPIO    = 3'd4
    } pin_fn_e;

    localparam int CFG_W        = 32;
    localparam int FN_LSB       = 0;
    localparam int DRV_LSB      = 4;
    localparam int IRQ_EN_BIT   = 8;
    localparam int OD_BIT       = 9;
    localparam int EDGE_LSB     = 16;
    localparam int LEVEL_BIT    = 8;

    typedef struct packed {
        logic [1:0] edge_sel;
        logic       open_drain;
        logic [1:0] drive;
        logic [2:0] fn;
    } drive_cfg_t;

endpackage

// File: rtl/tpin_sync.sv
module tpin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_state_t;

    sync_state_t st_d, st_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                st_d = st_q;
                st_d.chain[0] = pin_i;
                st_d.prev     = st_q.chain[STAGES-1];
            end
        end else begin : g_chain
            always_comb begin
                st_d = st_q;
                st_d.chain = {st_q.chain[STAGES-2:0], pin_i};
                st_d.prev  = st_q.chain[STAGES-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.chain[STAGES-1];
    assign rise_o  = st_q.chain[STAGES-1] & ~st_q.prev;
    assign fall_o  = ~st_q.chain[STAGES-1] & st_q.prev;

    // R7: a detected rising edge lasts exactly one cycle
    a_r7_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
    // R8: a detected falling edge lasts exactly one cycle
    a_r8_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/tpin_flags.sv
module tpin_flags #(
    parameter int FLAG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] set_i,
    input  logic [FLAG_W-1:0] clr_i,
    output logic [FLAG_W-1:0] flag_o
);
    typedef struct packed {
        logic [FLAG_W-1:0] flag;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.flag = (st_q.flag & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    // R9: a cleared flag with no new event reads zero next cycle
    a_r9_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[0] && !set_i[0]) |=> !flag_o[0]);
    // R10: an event in the same cycle as a clear keeps the flag
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i[0] && clr_i[0]) |=> flag_o[0]);
    // R9: a flag that is not cleared is never lost
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o[1] && !clr_i[1]) |=> flag_o[1]);

endmodule

// File: rtl/tpin_drive.sv
module tpin_drive
    import tpin_pkg::*;
(
    input  drive_cfg_t cfg_i,
    output logic       pin_oe_o,
    output logic       pin_out_o
);
    logic capture_on;
    logic gpio_on;

    always_comb begin
        capture_on = (cfg_i.edge_sel != 2'b00);
        gpio_on    = (cfg_i.fn == FN_GPIO);
        pin_oe_o   = 1'b0;
        pin_out_o  = 1'b0;
        if (!capture_on && gpio_on && cfg_i.drive[1]) begin
            if (cfg_i.drive[0]) begin
                pin_oe_o  = !cfg_i.open_drain;
                pin_out_o = !cfg_i.open_drain;
            end else begin
                pin_oe_o  = 1'b1;
                pin_out_o = 1'b0;
            end
        end
    end

endmodule

// File: rtl/tpin_ctrl.sv
module tpin_ctrl
    import tpin_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FLAG_W      = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_sel,
    input  logic        reg_we,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        pin_in,
    output logic        pin_out,
    output logic        pin_oe,
    output logic        irq
);
    localparam int PAD_LO_W = LEVEL_BIT - FLAG_W;
    localparam int PAD_HI_W = CFG_W - LEVEL_BIT - 1;

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    logic              level, rise, fall;
    logic [FLAG_W-1:0] flags, set_vec, clr_vec;
    logic [1:0]        edge_sel;
    drive_cfg_t        dcfg;

    always_comb begin
        st_d = st_q;
        if (reg_we && !reg_sel) st_d.cfg = reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign edge_sel = st_q.cfg[EDGE_LSB +: 2];

    always_comb begin
        dcfg.edge_sel   = edge_sel;
        dcfg.open_drain = st_q.cfg[OD_BIT];
        dcfg.drive      = st_q.cfg[DRV_LSB +: 2];
        dcfg.fn         = st_q.cfg[FN_LSB +: 3];
    end

    tpin_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin_in),
        .level_o (level),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    always_comb begin
        set_vec    = '0;
        set_vec[0] = rise & edge_sel[0];
        set_vec[1] = fall & edge_sel[1];
        clr_vec    = (reg_we && reg_sel) ? reg_wdata[FLAG_W-1:0] : '0;
    end

    tpin_flags #(.FLAG_W(FLAG_W)) i_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .flag_o (flags)
    );

    tpin_drive i_drive (
        .cfg_i     (dcfg),
        .pin_oe_o  (pin_oe),
        .pin_out_o (pin_out)
    );

    assign irq = (|flags) & st_q.cfg[IRQ_EN_BIT];

    always_comb begin
        if (reg_sel) reg_rdata = {{PAD_HI_W{1'b0}}, level, {PAD_LO_W{1'b0}}, flags};
        else         reg_rdata = st_q.cfg;
    end

    // R5: capture configured means the pad is never driven
    a_r5_capture_input_only: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel != 2'b00) |-> !pin_oe);
    // R4: open-drain never drives a high level
    a_r4_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe && st_q.cfg[OD_BIT]) |-> !pin_out);
    // R11: interrupt only with the enable bit set
    a_r11_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> st_q.cfg[IRQ_EN_BIT]);
    // R12: non-GPIO function never drives the pad
    a_r12_gpio_only: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg[FN_LSB +: 3] != 3'd4) |-> !pin_oe);

endmodule

// File: tb/test_tpin_ctrl.sv
module test_tpin_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pin_in = 1'b0;
    logic        pin_out, pin_oe, irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    tpin_ctrl i_tpin_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        reg_sel = sel;
        #1 v = reg_rdata;
    endtask

    task automatic set_pin(input logic v);
        pin_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic flags_are(input string req, input logic [3:0] exp);
        logic [31:0] v;
        rd(1'b1, v);
        check(req, {28'd0, v[3:0]}, {28'd0, exp});
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(1'b0, v);
        check("R1 cfg", v, 32'd0);
        flags_are("R1 flags", 4'h0);
        check("R1 oe", {31'd0, pin_oe}, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_cfg_rw;
        logic [31:0] v;
        wr(1'b0, 32'hA5C3_0E08);
        rd(1'b0, v);
        check("R2 readback", v, 32'hA5C3_0E08);
        wr(1'b0, 32'h0);
    endtask

    task automatic t_gpio_drive;
        wr(1'b0, 32'h0000_0034);
        check("R3 high", {30'd0, pin_oe, pin_out}, 32'd3);
        wr(1'b0, 32'h0000_0024);
        check("R3 low", {30'd0, pin_oe, pin_out}, 32'd2);
        wr(1'b0, 32'h0000_0014);
        check("R3 input", {31'd0, pin_oe}, 32'd0);
    endtask

    task automatic t_open_drain;
        wr(1'b0, 32'h0000_0234);
        check("R4 od high released", {31'd0, pin_oe}, 32'd0);
        wr(1'b0, 32'h0000_0224);
        check("R4 od low", {30'd0, pin_oe, pin_out}, 32'd2);
    endtask

    task automatic t_capture_input;
        wr(1'b0, 32'h0001_0034);
        check("R5 capture high drive", {31'd0, pin_oe}, 32'd0);
        wr(1'b0, 32'h0002_0024);
        check("R5 capture low drive", {31'd0, pin_oe}, 32'd0);
    endtask

    task automatic t_non_gpio;
        wr(1'b0, 32'h0000_0033);
        check("R12 pwm fn", {31'd0, pin_oe}, 32'd0);
        wr(1'b0, 32'h0000_0021);
        check("R12 capture fn", {31'd0, pin_oe}, 32'd0);
        wr(1'b0, 32'h0);
    endtask

    task automatic t_level;
        logic [31:0] v;
        pin_in = 1'b1;
        @(negedge clk); rd(1'b1, v);
        check("R6 after one edge", {31'd0, v[8]}, 32'd0);
        @(negedge clk); rd(1'b1, v);
        check("R6 after two edges", {31'd0, v[8]}, 32'd1);
        set_pin(1'b0);
        rd(1'b1, v);
        check("R6 low", {31'd0, v[8]}, 32'd0);
    endtask

    task automatic t_rise;
        wr(1'b0, 32'h0001_0001);
        wr(1'b1, 32'hF);
        set_pin(1'b1);
        flags_are("R7 rising sets bit0", 4'h1);
        set_pin(1'b0);
        flags_are("R7 falling ignored", 4'h1);
        wr(1'b1, 32'hF);
    endtask

    task automatic t_fall;
        wr(1'b0, 32'h0002_0001);
        set_pin(1'b1);
        flags_are("R8 rising ignored", 4'h0);
        set_pin(1'b0);
        flags_are("R8 falling sets bit1", 4'h2);
        wr(1'b1, 32'hF);
    endtask

    task automatic t_both_none;
        wr(1'b0, 32'h0003_0001);
        set_pin(1'b1);
        flags_are("R8 both rise", 4'h1);
        set_pin(1'b0);
        flags_are("R8 both fall", 4'h3);
        wr(1'b1, 32'hF);
        wr(1'b0, 32'h0000_0001);
        set_pin(1'b1);
        set_pin(1'b0);
        flags_are("R8 none selected", 4'h0);
    endtask

    task automatic t_w1c;
        wr(1'b0, 32'h0003_0001);
        set_pin(1'b1);
        set_pin(1'b0);
        flags_are("R9 setup", 4'h3);
        wr(1'b1, 32'h1);
        flags_are("R9 clear bit0 only", 4'h2);
        wr(1'b1, 32'h0);
        flags_are("R9 zero write keeps", 4'h2);
        wr(1'b1, 32'h2);
        flags_are("R9 clear bit1", 4'h0);
    endtask

    task automatic t_set_wins;
        wr(1'b0, 32'h0001_0001);
        wr(1'b1, 32'hF);
        pin_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr(1'b1, 32'h1);
        flags_are("R10 set beats clear", 4'h1);
        @(negedge clk);
        flags_are("R10 still set", 4'h1);
        wr(1'b1, 32'hF);
        set_pin(1'b0);
    endtask

    task automatic t_irq;
        wr(1'b0, 32'h0001_0001);
        set_pin(1'b1);
        check("R11 disabled", {31'd0, irq}, 32'd0);
        wr(1'b0, 32'h0001_0101);
        check("R11 enabled", {31'd0, irq}, 32'd1);
        wr(1'b1, 32'hF);
        check("R11 cleared", {31'd0, irq}, 32'd0);
        set_pin(1'b0);
        wr(1'b0, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg_rw();
        t_gpio_drive();
        t_open_drain();
        t_capture_input();
        t_non_gpio();
        t_level();
        t_rise();
        t_fall();
        t_both_none();
        t_w1c();
        t_set_wins();
        t_irq();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule